// File: doc/BRIEF.md
# Top-Three Ranking Selector

This block watches a bank of N unsigned small-integer values and names, every clock, which three of them hold the highest, the next highest and the third highest value. It compares every pair of values in one step and gives each value a rank from those results. The three winners come out as one-hot index vectors, one vector per rank. The block never reports the values themselves.

A fresh set of values may be presented on every clock. Each set is captured in an input register and ranked in one combinational pass. The three index vectors then land in output registers, two clocks after the set was presented. The block has no handshake: it accepts a new set every cycle and cannot apply back-pressure. The same code builds an 18-input and a 6-input variant through the element-count parameter.

Top module: `topsel_top`

## Requirements
- R1: Element k (0 to N-1) is carried on `din[k*W +: W]` and is treated as an unsigned number. The defaults are N=18 and W=4, and N must be at least 3.
- R2: `top1` is one-hot, with its set bit at the index of the element holding the largest value.
- R3: `top2` is one-hot, with its set bit at the index of the element holding the second-largest value.
- R4: `top3` is one-hot, with its set bit at the index of the element holding the third-largest value.
- R5: When values are equal, the element with the lower index ranks higher. When all values are equal, `top1`, `top2` and `top3` are bits 0, 1 and 2.
- R6: Once data has flowed, each output has exactly one bit set, and no two outputs share a bit.
- R7: The set presented before clock edge k appears on the outputs after edge k+1, which is a latency of two cycles. A new set is accepted on every cycle.
- R8: With `rst` high at a clock edge, all registers clear synchronously, and all three outputs read zero after that edge.
- R9: Comparison is strictly unsigned over all W bits, so a value with its top bit set (for example 8 or 15) beats 7 and every smaller value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | N*W | N packed unsigned values, element k at bits k*W +: W |
| top1 | output | N | One-hot index of the largest value |
| top2 | output | N | One-hot index of the second-largest value |
| top3 | output | N | One-hot index of the third-largest value |

## Verification
The in-RTL assertions check the following on every cycle:
- each output is one-hot and the outputs are disjoint;
- the values the outputs point at are in non-increasing order;
- among equal values, the lower index takes the higher rank;
- the outputs clear after reset.

These checks cannot tell whether the right elements were chosen. That needs the bench's scenarios, which compare the outputs against an independent search for the maximum. Those scenarios also cover the two-cycle timing of a back-to-back stream, an all-equal set, values with the top bit set, and a reset in the middle of a stream.

// File: rtl/topsel_pkg.sv
package topsel_pkg;
  localparam int RANKS = 3;
endpackage

// File: rtl/topsel_beat_matrix.sv
module topsel_beat_matrix #(
  parameter int N = 18,
  parameter int W = 4
) (
  input  logic [N*W-1:0] vals,
  output logic [N*N-1:0] beaten
);
  // beaten[i*N+j] set: element j outranks element i.
  // One strict unsigned compare per unordered pair (R9).
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        assign beaten[i*N+j] = 1'b0;
      end else if (i < j) begin : g_pair
        logic hi_wins;
        // Higher index wins only on strictly larger value (R5).
        assign hi_wins = vals[j*W +: W] > vals[i*W +: W];
        assign beaten[i*N+j] = hi_wins;
        assign beaten[j*N+i] = ~hi_wins;
      end
    end
  end
endmodule

// File: rtl/topsel_rank_count.sv
module topsel_rank_count #(
  parameter int N  = 18,
  parameter int CW = $clog2(N)
) (
  input  logic [N*N-1:0]  beaten,
  output logic [N*CW-1:0] ranks
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [CW-1:0] acc;
      acc = '0;
      for (int j = 0; j < N; j++) begin
        acc = acc + CW'(beaten[i*N+j]);
      end
      ranks[i*CW +: CW] = acc;
    end
  end
endmodule

// File: rtl/topsel_onehot.sv
module topsel_onehot #(
  parameter int N     = 18,
  parameter int CW    = $clog2(N),
  parameter int RANKS = topsel_pkg::RANKS
) (
  input  logic [N*CW-1:0]           ranks,
  output logic [RANKS-1:0][N-1:0]   hot
);
  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    for (genvar i = 0; i < N; i++) begin : g_elem
      assign hot[r][i] = (ranks[i*CW +: CW] == CW'(r));
    end
  end
endmodule

// File: rtl/topsel_top.sv
module topsel_top #(
  parameter int N = 18,
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N*W-1:0] din,
  output logic [N-1:0]   top1,
  output logic [N-1:0]   top2,
  output logic [N-1:0]   top3
);
  localparam int CW    = $clog2(N);
  localparam int RANKS = topsel_pkg::RANKS;

  logic [N*W-1:0]            din_q;
  logic [N*N-1:0]            beaten;
  logic [N*CW-1:0]           ranks;
  logic [RANKS-1:0][N-1:0]   hot;
  logic [1:0]                fill;

  // Input stage (R7, R8)
  always_ff @(posedge clk) begin
    if (rst) din_q <= '0;
    else     din_q <= din;
  end

  topsel_beat_matrix #(.N(N), .W(W)) u_matrix (
    .vals   (din_q),
    .beaten (beaten)
  );

  topsel_rank_count #(.N(N), .CW(CW)) u_count (
    .beaten (beaten),
    .ranks  (ranks)
  );

  topsel_onehot #(.N(N), .CW(CW), .RANKS(RANKS)) u_onehot (
    .ranks (ranks),
    .hot   (hot)
  );

  // Output stage (R2, R3, R4, R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      top1 <= '0;
      top2 <= '0;
      top3 <= '0;
    end else begin
      top1 <= hot[0];
      top2 <= hot[1];
      top3 <= hot[2];
    end
  end

  // Pipeline fill tracker, used only by the checks below.
  always_ff @(posedge clk) begin
    if (rst)            fill <= '0;
    else if (fill != 2) fill <= fill + 2'd1;
  end

  function automatic logic [W-1:0] pick(input logic [N*W-1:0] v,
                                        input logic [N-1:0] oh);
    logic [W-1:0] res;
    res = '0;
    for (int i = 0; i < N; i++) if (oh[i]) res = res | v[i*W +: W];
    return res;
  endfunction

  // R6
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (fill == 2) |-> ($countones(top1) == 1 && $countones(top2) == 1 &&
                     $countones(top3) == 1));

  // R6
  disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    ((top1 & top2) | (top1 & top3) | (top2 & top3)) == '0);

  // R2 R3 R4
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (fill == 2) |-> (pick($past(din_q), top1) >= pick($past(din_q), top2) &&
                     pick($past(din_q), top2) >= pick($past(din_q), top3)));

  // R5
  tie_chk: assert property (@(posedge clk) disable iff (rst)
    (fill == 2 && pick($past(din_q), top1) == pick($past(din_q), top2))
      |-> (top1 < top2));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (top1 == '0 && top2 == '0 && top3 == '0));
endmodule

// File: tb/topsel_top_bench.sv
`timescale 1ns/1ps
module topsel_top_bench;
  localparam int N = 18;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N*W-1:0] din = '0;
  logic [N-1:0]   top1, top2, top3;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  topsel_top #(.N(N), .W(W)) u_topsel_top (
    .clk(clk), .rst(rst), .din(din),
    .top1(top1), .top2(top2), .top3(top3)
  );

  // Independent reference: repeated maximum search, lowest index on ties.
  task automatic expect_of(input logic [N*W-1:0] v, output logic [N-1:0] e1,
                           output logic [N-1:0] e2, output logic [N-1:0] e3);
    logic [N-1:0] taken;
    logic [N-1:0] res [3];
    taken = '0;
    for (int r = 0; r < 3; r++) begin
      int best;
      best = -1;
      for (int i = 0; i < N; i++) begin
        if (!taken[i]) begin
          if (best < 0) best = i;
          else if (v[i*W +: W] > v[best*W +: W]) best = i;
        end
      end
      res[r] = '0;
      res[r][best] = 1'b1;
      taken[best] = 1'b1;
    end
    e1 = res[0]; e2 = res[1]; e3 = res[2];
  endtask

  task automatic cmp(input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [N*W-1:0] v);
    logic [N-1:0] e1, e2, e3;
    expect_of(v, e1, e2, e3);
    cmp({req, " top1 (R2)"}, top1, e1);
    cmp({req, " top2 (R3)"}, top2, e2);
    cmp({req, " top3 (R4)"}, top3, e3);
  endtask

  // Drive at a falling edge, capture, rank, then sample two falling edges later.
  task automatic apply_and_check(input string req, input logic [N*W-1:0] v);
    @(negedge clk) din = v;
    @(negedge clk);
    @(negedge clk);
    check_all(req, v);
  endtask

  function automatic logic [N*W-1:0] gen(input int k);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'((k * 7 + i * 5 + (k * i) % 3) % 16);
    return v;
  endfunction

  task automatic t_reset;
    @(negedge clk);
    cmp("R8 reset top1", top1, '0);
    cmp("R8 reset top2", top2, '0);
    cmp("R8 reset top3", top3, '0);
  endtask

  task automatic t_distinct;
    logic [N*W-1:0] v;
    // R1 distinct values, winners spread over the index range
    v = '0;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i % 11);
    v[13*W +: W] = 4'd14; v[4*W +: W] = 4'd13; v[16*W +: W] = 4'd12;
    apply_and_check("R1 distinct", v);
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i < 16 ? i : 0);
    apply_and_check("R1 ascending", v);
  endtask

  task automatic t_all_equal;
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = 4'd9;
    apply_and_check("R5 all equal", v);
    cmp("R5 equal top1 bit0", top1, N'(1));
    cmp("R5 equal top2 bit1", top2, N'(2));
    cmp("R5 equal top3 bit2", top3, N'(4));
  endtask

  task automatic t_ties;
    logic [N*W-1:0] v;
    v = '0;
    v[17*W +: W] = 4'd10; v[5*W +: W] = 4'd10; v[11*W +: W] = 4'd10;
    v[2*W +: W] = 4'd3;
    apply_and_check("R5 three way tie", v);
    cmp("R5 tie top1 idx5", top1, N'(1) << 5);
    cmp("R5 tie top3 idx17", top3, N'(1) << 17);
  endtask

  task automatic t_high_bit;
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = 4'd7;
    v[9*W +: W] = 4'd8; v[1*W +: W] = 4'd15;
    apply_and_check("R9 unsigned top bit", v);
    cmp("R9 15 first", top1, N'(1) << 1);
    cmp("R9 8 second", top2, N'(1) << 9);
  endtask

  task automatic t_stream;
    localparam int S = 40;
    for (int k = 0; k < S + 2; k++) begin
      @(negedge clk);
      if (k >= 2) check_all("R7 stream", gen(k - 2));
      if (k < S) din = gen(k);
    end
  endtask

  task automatic t_mid_reset;
    apply_and_check("R7 before reset", gen(3));
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    cmp("R8 mid top1", top1, '0);
    cmp("R8 mid top2", top2, '0);
    cmp("R8 mid top3", top3, '0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_all("R8 after release", gen(3));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst = 1'b0;
    t_distinct();
    t_all_equal();
    t_ties();
    t_high_bit();
    t_stream();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule